// File: doc/BRIEF.md
# Sample-Fetch DMA Stall Scheduler

This block decides when a sample-playback channel may take the CPU bus to read its next sample byte. It drives an active-high ready line that stalls CPU read cycles, a strobe on the cycle where the memory read happens, and a strobe that marks the end of each fetch. A fetch of the first kind, the load fetch, follows a write to the channel-enable register. A fetch of the second kind, the reload fetch, starts when the playback buffer reports empty while the channel is enabled. The sample decoder and the sprite-copy DMA engine are outside the block. The address counter that sits beside it steps on each fetch strobe.

Every cycle the scheduler is told whether the CPU cycle is a read or a write and whether it is a get or a put cycle. Get and put cycles alternate. The CPU cannot be halted on a write, so a stall request that meets a write is held and tried again on the next cycle. The memory read itself must land on a get cycle, so the stall is 3 or 4 cycles long depending on the parity of the first read cycle that is halted. A load fetch that collides with the write that starts a sprite-copy DMA shares that engine's halt and costs two cycles. An optional mode adds a spurious one-cycle stall shortly after a load fetch.

The state machine has these states. ST_IDLE waits for work. ST_LWAIT counts the cycles after the enable write. ST_LLATE is the one extra wait that lines the load up with a get cycle. ST_HALT holds the stall request until a read cycle comes. ST_DUMMY is the halted cycle after the halt. ST_ALIGN is the extra cycle that puts the read on a get cycle. ST_FETCH is the memory read. ST_SH1 and ST_SH2 are the two cycles shared with a sprite-copy DMA. ST_GAP is the run-free gap after a load fetch. ST_SPUR is the possible spurious stall.

The transitions are as follows.
- ST_IDLE goes to ST_LWAIT on an enable write of 1 while the buffer is empty.
- ST_IDLE goes to ST_HALT on buffer empty while enabled and no enable write is present.
- ST_LWAIT goes to ST_LLATE or ST_HALT once the counter reaches the last wait cycle. It goes to ST_IDLE on an enable write of 0.
- ST_LLATE goes to ST_HALT, or to ST_IDLE on an enable write of 0.
- ST_HALT stays in place on a write cycle. It goes to ST_SH1 on a sprite-copy trigger write during a load. It goes to ST_DUMMY on a read cycle.
- ST_DUMMY goes to ST_ALIGN if the dummy cycle is a get cycle, and to ST_FETCH otherwise.
- ST_ALIGN goes to ST_FETCH.
- ST_FETCH of a reload goes to ST_IDLE. ST_FETCH of a load goes to ST_HALT for a back-to-back reload, or to ST_GAP otherwise.
- ST_SH1 goes to ST_SH2, and ST_SH2 goes to ST_GAP.
- ST_GAP goes to ST_SPUR when its counter is full, and ST_SPUR goes to ST_IDLE.

Top module: `smp_fetch_sched`

## Requirements
- R1: After reset, ready is high and neither strobe is asserted while no enable write and no buffer-empty input arrives.
- R2: After an enable write of 1 with the buffer empty in cycle t, ready first drops in cycle t+3 if that is a get cycle, and otherwise in cycle t+4 (a get cycle).
- R3: The fetch strobe is asserted only on get cycles and only while ready is low. The fetch-done strobe is asserted on the fetch strobe's cycle, or on the cycle after it for a shared sprite-copy stall.
- R4: A load fetch that meets no write cycle stalls 3 read cycles. One write cycle at its first stall cycle gives 4 read-cycle stalls. Two consecutive writes give 3. Ready is low through each write cycle during which the stall is still requested.
- R5: With the channel enabled, a buffer-empty input in an idle cycle c drops ready from cycle c+1. The first read cycle with ready low starts a stall of 3 cycles if it is a get cycle and 4 if it is a put cycle. Earlier write cycles only defer it.
- R6: If a load fetch's stall request meets a write cycle with the sprite-copy start flag set, ready is low for exactly the next two cycles. The fetch strobe comes on whichever of the two is a get cycle, and fetch-done comes on the second.
- R7: With the spurious-stall mode on, ready drops for one cycle exactly 3 cycles after a load fetch's done strobe, leaving 2 ready cycles between. It does not drop if that cycle is a write, after a reload fetch, or when the mode is off.
- R8: If buffer-empty is high in the done cycle of a load fetch while enabled, ready stays low and a reload stall begins in the next cycle. This reload produces a second fetch strobe and no spurious stall.
- R9: An enable write of 0 during the load wait cancels the load, so there is no stall and no strobe. With the channel disabled, buffer-empty starts no fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU cycle clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_write | input | 1 | Current CPU cycle is a write |
| cyc_get | input | 1 | Current cycle is a get cycle (alternates with put) |
| en_wr | input | 1 | Channel-enable register written this cycle |
| en_val | input | 1 | Value of the enable bit being written |
| buf_empty | input | 1 | Playback buffer holds no byte |
| spr_start | input | 1 | This write starts a sprite-copy DMA |
| spur_en | input | 1 | Enables the spurious one-cycle stall |
| rdy | output | 1 | CPU ready; low requests a stall |
| fetch_stb | output | 1 | Memory read of a sample byte happens this cycle |
| fetch_done | output | 1 | Last cycle of a fetch |

## Verification
The bench sweeps the parity of the enable write, zero to two deferring write cycles, spurious mode on and off, and a write on the spurious cycle. It derives every ready and strobe value from the parity arithmetic alone. A design that picked the load start cycle without regard to parity would stall one cycle early or late. One that counted writes into the stall length would give 5 or 6 cycles where 3 or 4 are due. One that took the fetch read on a put cycle would fail the get-cycle check. The bench also covers the sprite-copy collision, the back-to-back reload, cancellation by a disabling write, and reloads with the channel disabled. These catch a scheduler that ignores the shared halt, leaves a gap before the second fetch, emits a stray spurious stall, or fetches after being disabled.

// File: rtl/smp_fetch_pkg.sv
`timescale 1ns/1ps
package smp_fetch_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_LWAIT,
        ST_LLATE,
        ST_HALT,
        ST_DUMMY,
        ST_ALIGN,
        ST_FETCH,
        ST_SH1,
        ST_SH2,
        ST_GAP,
        ST_SPUR
    } sched_state_t;

endpackage

// File: rtl/smp_fetch_enable.sv
`timescale 1ns/1ps
module smp_fetch_enable (
    input  logic clk,
    input  logic rst_n,
    input  logic en_wr,
    input  logic en_val,
    output logic en_q
);

    // Delayed channel enable: takes the written bit one cycle after the write.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= 1'b0;
        end else if (en_wr) begin
            en_q <= en_val;
        end
    end

endmodule

// File: rtl/smp_fetch_seq.sv
`timescale 1ns/1ps
module smp_fetch_seq
    import smp_fetch_pkg::*;
#(
    parameter int LOAD_LEAD = 3,
    parameter int SPUR_GAP  = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cyc_write,
    input  logic         cyc_get,
    input  logic         en_wr,
    input  logic         en_val,
    input  logic         en_q,
    input  logic         buf_empty,
    input  logic         spr_start,
    output sched_state_t state
);

    localparam int MAXC = (LOAD_LEAD > SPUR_GAP) ? LOAD_LEAD : SPUR_GAP;
    localparam int CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] LEAD_LAST = CW'(LOAD_LEAD - 1);
    localparam logic [CW-1:0] GAP_LAST  = CW'(SPUR_GAP);
    localparam logic [CW-1:0] CNT_ONE   = CW'(1);

    sched_state_t    nxt;
    logic [CW-1:0]   cnt;
    logic [CW-1:0]   cnt_n;
    logic            is_load;
    logic            load_n;
    logic            cancel;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            is_load <= 1'b0;
        end else begin
            state   <= nxt;
            cnt     <= cnt_n;
            is_load <= load_n;
        end
    end

    always_comb begin
        nxt    = state;
        cnt_n  = cnt;
        load_n = is_load;
        cancel = en_wr && !en_val;
        unique case (state)
            ST_IDLE: begin
                if (en_wr && en_val && buf_empty) begin
                    nxt    = ST_LWAIT;
                    cnt_n  = CNT_ONE;
                    load_n = 1'b1;
                end else if (en_q && buf_empty && !en_wr) begin
                    nxt    = ST_HALT;
                    load_n = 1'b0;
                end
            end
            ST_LWAIT: begin
                if (cancel) begin
                    nxt = ST_IDLE;
                end else if (cnt == LEAD_LAST) begin
                    // next cycle is a put when this one is a get
                    nxt = cyc_get ? ST_LLATE : ST_HALT;
                end else begin
                    cnt_n = cnt + 1'b1;
                end
            end
            ST_LLATE: begin
                nxt = cancel ? ST_IDLE : ST_HALT;
            end
            ST_HALT: begin
                if (cyc_write) begin
                    if (spr_start && is_load) begin
                        nxt = ST_SH1;
                    end
                end else begin
                    nxt = ST_DUMMY;
                end
            end
            ST_DUMMY: begin
                nxt = cyc_get ? ST_ALIGN : ST_FETCH;
            end
            ST_ALIGN: begin
                nxt = ST_FETCH;
            end
            ST_FETCH: begin
                if (!is_load) begin
                    nxt = ST_IDLE;
                end else if (buf_empty && en_q) begin
                    nxt    = ST_HALT;
                    load_n = 1'b0;
                end else begin
                    nxt   = ST_GAP;
                    cnt_n = CNT_ONE;
                end
            end
            ST_SH1: begin
                nxt = ST_SH2;
            end
            ST_SH2: begin
                nxt   = ST_GAP;
                cnt_n = CNT_ONE;
            end
            ST_GAP: begin
                if (cnt == GAP_LAST) begin
                    nxt = ST_SPUR;
                end else begin
                    cnt_n = cnt + 1'b1;
                end
            end
            ST_SPUR: begin
                nxt = ST_IDLE;
            end
            default: begin
                nxt = ST_IDLE;
            end
        endcase
    end

endmodule

// File: rtl/smp_fetch_outdec.sv
`timescale 1ns/1ps
module smp_fetch_outdec
    import smp_fetch_pkg::*;
(
    input  sched_state_t state,
    input  logic         cyc_write,
    input  logic         cyc_get,
    input  logic         spur_en,
    output logic         rdy,
    output logic         fetch_stb,
    output logic         fetch_done
);

    always_comb begin
        rdy        = 1'b1;
        fetch_stb  = 1'b0;
        fetch_done = 1'b0;
        unique case (state)
            ST_HALT, ST_DUMMY, ST_ALIGN: begin
                rdy = 1'b0;
            end
            ST_FETCH: begin
                rdy        = 1'b0;
                fetch_stb  = 1'b1;
                fetch_done = 1'b1;
            end
            ST_SH1: begin
                rdy       = 1'b0;
                fetch_stb = cyc_get;
            end
            ST_SH2: begin
                rdy        = 1'b0;
                fetch_stb  = cyc_get;
                fetch_done = 1'b1;
            end
            ST_SPUR: begin
                rdy = !(spur_en && !cyc_write);
            end
            default: begin
                rdy = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/smp_fetch_sched.sv
`timescale 1ns/1ps
module smp_fetch_sched
    import smp_fetch_pkg::*;
#(
    parameter int LOAD_LEAD = 3,
    parameter int SPUR_GAP  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cyc_write,
    input  logic cyc_get,
    input  logic en_wr,
    input  logic en_val,
    input  logic buf_empty,
    input  logic spr_start,
    input  logic spur_en,
    output logic rdy,
    output logic fetch_stb,
    output logic fetch_done
);

    logic         en_q;
    sched_state_t state;

    smp_fetch_enable u_enable (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_wr  (en_wr),
        .en_val (en_val),
        .en_q   (en_q)
    );

    smp_fetch_seq #(
        .LOAD_LEAD (LOAD_LEAD),
        .SPUR_GAP  (SPUR_GAP)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cyc_write (cyc_write),
        .cyc_get   (cyc_get),
        .en_wr     (en_wr),
        .en_val    (en_val),
        .en_q      (en_q),
        .buf_empty (buf_empty),
        .spr_start (spr_start),
        .state     (state)
    );

    smp_fetch_outdec u_outdec (
        .state      (state),
        .cyc_write  (cyc_write),
        .cyc_get    (cyc_get),
        .spur_en    (spur_en),
        .rdy        (rdy),
        .fetch_stb  (fetch_stb),
        .fetch_done (fetch_done)
    );

endmodule

// File: rtl/smp_fetch_chk.sv
`timescale 1ns/1ps
module smp_fetch_chk (
    input logic clk,
    input logic rst_n,
    input logic cyc_get,
    input logic buf_empty,
    input logic rdy,
    input logic fetch_stb,
    input logic fetch_done
);

    AST_STB_ON_GET: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_stb |-> cyc_get); // R3

    AST_STB_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_stb |-> !rdy); // R3

    AST_DONE_WITH_STB: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_done |-> (fetch_stb || $past(fetch_stb))); // R6

    AST_RDY_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_done && !buf_empty) |=> rdy); // R8

    AST_STB_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_stb |=> !fetch_stb); // R4

endmodule

bind smp_fetch_sched smp_fetch_chk i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cyc_get    (cyc_get),
    .buf_empty  (buf_empty),
    .rdy        (rdy),
    .fetch_stb  (fetch_stb),
    .fetch_done (fetch_done)
);

// File: tb/test_smp_fetch_sched.sv
`timescale 1ns/1ps
module test_smp_fetch_sched;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cyc_write = 1'b0;
    logic en_wr = 1'b0;
    logic en_val = 1'b0;
    logic buf_empty = 1'b0;
    logic spr_start = 1'b0;
    logic spur_en = 1'b0;
    logic rdy, fetch_stb, fetch_done;
    logic cyc_get;

    int cnum = 0;
    int base = 0;
    int checks = 0;
    int errors = 0;

    bit w_a  [0:31];
    bit en_a [0:31];
    bit v_a  [0:31];
    bit be_a [0:31];
    bit sp_a [0:31];
    bit xr   [0:31];
    bit xs   [0:31];
    bit xd   [0:31];

    always #2.5 clk = ~clk;

    assign cyc_get = ((cnum % 2) == 0);

    smp_fetch_sched i_smp_fetch_sched (
        .clk        (clk),
        .rst_n      (rst_n),
        .cyc_write  (cyc_write),
        .cyc_get    (cyc_get),
        .en_wr      (en_wr),
        .en_val     (en_val),
        .buf_empty  (buf_empty),
        .spr_start  (spr_start),
        .spur_en    (spur_en),
        .rdy        (rdy),
        .fetch_stb  (fetch_stb),
        .fetch_done (fetch_done)
    );

    function automatic bit gg(input int i);
        return ((base + i) % 2) == 0;
    endfunction

    task automatic step(input bit w, input bit en, input bit v, input bit be,
                        input bit sp, output bit r, output bit s, output bit d);
        @(posedge clk);
        #1;
        cnum++;
        cyc_write = w;
        en_wr     = en;
        en_val    = v;
        buf_empty = be;
        spr_start = sp;
        #2;
        r = rdy;
        s = fetch_stb;
        d = fetch_done;
    endtask

    task automatic clear_win();
        for (int i = 0; i < 32; i++) begin
            w_a[i] = 0; en_a[i] = 0; v_a[i] = 0; be_a[i] = 0; sp_a[i] = 0;
            xr[i] = 1; xs[i] = 0; xd[i] = 0;
        end
    endtask

    // make the first window cycle a get cycle when par is 1, a put cycle otherwise
    task automatic align(input bit par);
        bit r, s, d;
        while ((((cnum + 1) % 2) == 0) != par) begin
            step(0, 0, 0, 0, 0, r, s, d);
        end
        base = cnum + 1;
    endtask

    task automatic run_win(input string tag, input int n);
        for (int i = 0; i < n; i++) begin
            bit r, s, d;
            step(w_a[i], en_a[i], v_a[i], be_a[i], sp_a[i], r, s, d);
            checks++;
            if (r !== xr[i] || s !== xs[i] || d !== xd[i]) begin
                errors++;
                $display("FAIL %s cycle %0d: rdy/stb/done actual %b%b%b expected %b%b%b",
                         tag, i, r, s, d, xr[i], xs[i], xd[i]);
            end
            if (s) begin
                checks++;
                if (!gg(i)) begin
                    errors++;
                    $display("FAIL R3 cycle %0d: strobe on get actual 0 expected 1", i);
                end
            end
        end
    endtask

    task automatic stall_span(input int h0, input int f);
        for (int i = h0; i <= f; i++) xr[i] = 0;
        xs[f] = 1;
        xd[f] = 1;
    endtask

    task automatic load_case(input string tag, input bit par, input int nw,
                             input bit spe, input bit spw, input bit b2b);
        int h0, h, len, f, h2, f2, sp;
        spur_en = spe;
        align(par);
        clear_win();
        w_a[0] = 1; en_a[0] = 1; v_a[0] = 1; be_a[0] = 1;
        h0 = gg(3) ? 3 : 4;                    // R2
        for (int k = 0; k < nw; k++) w_a[h0 + k] = 1;
        h   = h0 + nw;
        len = gg(h) ? 3 : 4;                   // R4
        f   = h + len - 1;
        stall_span(h0, f);
        if (b2b) begin                         // R8
            be_a[f] = 1;
            h2 = f + 1;
            f2 = h2 + (gg(h2) ? 3 : 4) - 1;
            stall_span(h2, f2);
        end else begin                         // R7
            sp = f + 3;
            if (spw) w_a[sp] = 1;
            if (spe && !spw) xr[sp] = 0;
        end
        run_win(tag, 20);
    endtask

    task automatic reload_case(input bit par, input int nw);
        int h, f;
        spur_en = 1;
        align(par);
        clear_win();
        be_a[0] = 1;
        for (int k = 0; k < nw; k++) w_a[1 + k] = 1;
        h = 1 + nw;
        f = h + (gg(h) ? 3 : 4) - 1;
        stall_span(1, f);                      // no spurious stall after reload
        run_win("R5", 20);
    endtask

    task automatic sprite_case(input bit par, input bit spe);
        int h0, s1;
        spur_en = spe;
        align(par);
        clear_win();
        w_a[0] = 1; en_a[0] = 1; v_a[0] = 1; be_a[0] = 1;
        h0 = gg(3) ? 3 : 4;
        w_a[h0] = 1; sp_a[h0] = 1;
        for (int i = h0; i <= h0 + 2; i++) xr[i] = 0;
        s1 = gg(h0 + 1) ? h0 + 1 : h0 + 2;
        xs[s1] = 1;
        xd[h0 + 2] = 1;
        if (spe) xr[h0 + 5] = 0;
        run_win("R6", 20);
    endtask

    task automatic cancel_case(input bit par, input int ci);
        spur_en = 1;
        align(par);
        clear_win();
        w_a[0] = 1; en_a[0] = 1; v_a[0] = 1; be_a[0] = 1;
        w_a[ci] = 1; en_a[ci] = 1; v_a[ci] = 0;
        be_a[10] = 1;                          // disabled: must start nothing
        run_win("R9", 20);
    endtask

    initial begin
        #(5.0 * 200000);
        errors++;
        $display("FAIL watchdog: run actual hung expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        clear_win();
        base = cnum + 1;
        run_win("R1", 6);

        for (int p = 0; p < 2; p++) begin
            for (int spe = 0; spe < 2; spe++) begin
                load_case("R2", p[0], 0, spe[0], 0, 0);
                load_case("R4", p[0], 1, spe[0], 0, 0);
                load_case("R4", p[0], 2, spe[0], 0, 0);
            end
            load_case("R7", p[0], 0, 1, 1, 0);
            load_case("R7", p[0], 1, 1, 1, 0);
            load_case("R8", p[0], 0, 1, 0, 1);
            load_case("R8", p[0], 1, 0, 0, 1);
            for (int nw = 0; nw < 3; nw++) reload_case(p[0], nw);
            sprite_case(p[0], 0);
            sprite_case(p[0], 1);
            for (int ci = 1; ci < 3; ci++) cancel_case(p[0], ci);
            load_case("R4", p[0], 0, 0, 0, 0);   // re-enable after cancel
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule